// File: doc/BRIEF.md
# Prescaled Periodic Update Timer

This block is a basic up-counting timer driven through a small synchronous register port. A programmable divider slows the input clock by (divide value + 1); each divided tick advances a 16-bit counter, and when the counter has reached the wrap limit the next tick returns it to zero and produces an update event. An update event sets a sticky flag, which drives a level interrupt when enabled, and can also produce a single-cycle DMA request pulse.

Divide and limit writes land in preload registers and reach the live counting logic only on an update event. Software can force an update at any time by writing to a self-clearing trigger register. This restarts the counter and the divider and loads the preloads. A source-select bit lets a forced update run silently: it reloads and restarts, but it neither raises the flag nor requests DMA. The counting path is a two-state machine. HOLD moves to RUN on the START transition (enable bit set) and RUN moves back to HOLD on the STOP transition (enable bit cleared). Counting happens only in RUN, so the counter begins advancing one cycle after the enable write lands.

Top module: `tmr_timer`

## Requirements
- R1: After reset, every register reads zero except the limit register, which reads 0x0000FFFF. irq and dma_req are low.
- R2: While running, the counter advances once every DIV+1 clock cycles. After it has reached LIMIT, the next tick takes it to 0 and raises an overflow update, so overflow updates are spaced (DIV+1)*(LIMIT+1) cycles apart. A divide of 19 with a limit of 35 gives 720 cycles, which is the 72 MHz one-second ratio scaled down by 100000.
- R3: Bit 0 of the control register (offset 0x00) enables counting. While it is 0, the counter and the divider keep their values.
- R4: The divide register (offset 0x28) and the limit register (offset 0x2C) read back the written value at once, but counting keeps the old values until the next update event.
- R5: Writing 1 to bit 0 of the trigger register (offset 0x14) forces an update. The counter and the divider go to 0 and the preloads become active. The register always reads 0.
- R6: An update event sets the flag in bit 0 of the status register (offset 0x10). Writing 0 to that bit clears the flag, and writing 1 leaves it unchanged. Bit 31 of the counter register mirrors the flag.
- R7: When bit 2 of the control register is 1, a forced update still restarts the counter and reloads, but it sets no flag and makes no DMA request.
- R8: irq equals the flag ANDed with bit 0 of the enable register (offset 0x0C).
- R9: When bit 8 of the enable register is 1, each flag-setting update produces a dma_req pulse one cycle long, in the cycle after the event.
- R10: With an active limit of 0, the counter stays at 0 and no overflow updates occur.
- R11: Bits 15:0 of the counter register (offset 0x24) are writable and load the counter directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 6 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational from bus_addr) |
| irq | output | 1 | Update interrupt level |
| dma_req | output | 1 | Single-cycle update DMA request |

## Verification
The hardest behaviour to expose is the gap between the preload and active copies of divide and limit, because the ports only ever show the preload. The bench runs with a small new limit under the large reset-time active limit and watches the count pass the new limit. It then forces an update and confirms that the count now wraps at the new limit. The wrap period is swept over many small divide/limit pairs, and each pair is measured as the spacing between consecutive DMA pulses.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int ADDR_W = 6;

    localparam logic [ADDR_W-1:0] OFS_CTRL = 6'h00;
    localparam logic [ADDR_W-1:0] OFS_IEN  = 6'h0C;
    localparam logic [ADDR_W-1:0] OFS_STAT = 6'h10;
    localparam logic [ADDR_W-1:0] OFS_TRIG = 6'h14;
    localparam logic [ADDR_W-1:0] OFS_CNT  = 6'h24;
    localparam logic [ADDR_W-1:0] OFS_DIV  = 6'h28;
    localparam logic [ADDR_W-1:0] OFS_LIM  = 6'h2C;

    localparam int BIT_EN  = 0;
    localparam int BIT_SRC = 2;
    localparam int BIT_IE  = 0;
    localparam int BIT_DE  = 8;

    typedef enum logic [0:0] {
        S_HOLD = 1'b0,
        S_RUN  = 1'b1
    } run_state_t;
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16,
    parameter int PSC_W  = 16,
    parameter logic [CNT_W-1:0] LIM_RST = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [CNT_W-1:0]  cnt_q,
    input  logic              uif_set,
    output logic              en,
    output logic              urs,
    output logic              uie,
    output logic              ude,
    output logic              uif,
    output logic [PSC_W-1:0]  div_pre,
    output logic [CNT_W-1:0]  lim_pre,
    output logic              sw_upd,
    output logic              cnt_wr,
    output logic [CNT_W-1:0]  cnt_wdata
);
    logic wr_ctrl, wr_ien, wr_stat, wr_div, wr_lim;

    assign wr_ctrl   = bus_we && (bus_addr == OFS_CTRL);
    assign wr_ien    = bus_we && (bus_addr == OFS_IEN);
    assign wr_stat   = bus_we && (bus_addr == OFS_STAT);
    assign wr_div    = bus_we && (bus_addr == OFS_DIV);
    assign wr_lim    = bus_we && (bus_addr == OFS_LIM);
    assign sw_upd    = bus_we && (bus_addr == OFS_TRIG) && bus_wdata[0];
    assign cnt_wr    = bus_we && (bus_addr == OFS_CNT);
    assign cnt_wdata = bus_wdata[CNT_W-1:0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en      <= 1'b0;
            urs     <= 1'b0;
            uie     <= 1'b0;
            ude     <= 1'b0;
            uif     <= 1'b0;
            div_pre <= '0;
            lim_pre <= LIM_RST;
        end else begin
            if (wr_ctrl) begin
                en  <= bus_wdata[BIT_EN];
                urs <= bus_wdata[BIT_SRC];
            end
            if (wr_ien) begin
                uie <= bus_wdata[BIT_IE];
                ude <= bus_wdata[BIT_DE];
            end
            if (uif_set)
                uif <= 1'b1;
            else if (wr_stat)
                uif <= uif & bus_wdata[0];
            if (wr_div)
                div_pre <= bus_wdata[PSC_W-1:0];
            if (wr_lim)
                lim_pre <= bus_wdata[CNT_W-1:0];
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_CTRL: begin
                bus_rdata[BIT_EN]  = en;
                bus_rdata[BIT_SRC] = urs;
            end
            OFS_IEN: begin
                bus_rdata[BIT_IE] = uie;
                bus_rdata[BIT_DE] = ude;
            end
            OFS_STAT: bus_rdata[0] = uif;
            OFS_CNT: begin
                bus_rdata[CNT_W-1:0]  = cnt_q;
                bus_rdata[DATA_W-1]   = uif;
            end
            OFS_DIV: bus_rdata[PSC_W-1:0] = div_pre;
            OFS_LIM: bus_rdata[CNT_W-1:0] = lim_pre;
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/tmr_presc.sv
module tmr_presc #(
    parameter int PSC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clear,
    input  logic [PSC_W-1:0] div_act,
    output logic             tick
);
    logic [PSC_W-1:0] pdiv_q;

    assign tick = run && (pdiv_q == div_act);

    always_ff @(posedge clk) begin
        if (!rst_n)
            pdiv_q <= '0;
        else if (clear)
            pdiv_q <= '0;
        else if (run)
            pdiv_q <= tick ? '0 : pdiv_q + 1'b1;
    end
endmodule

// File: rtl/tmr_core.sv
module tmr_core
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PSC_W = 16,
    parameter logic [CNT_W-1:0] LIM_RST = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             urs,
    input  logic             ude,
    input  logic             sw_upd,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic [PSC_W-1:0] div_pre,
    input  logic [CNT_W-1:0] lim_pre,
    input  logic             tick,
    output run_state_t       state,
    output logic [PSC_W-1:0] div_act,
    output logic [CNT_W-1:0] lim_act,
    output logic [CNT_W-1:0] cnt_q,
    output logic             ovf,
    output logic             uif_set,
    output logic             dma_req
);
    run_state_t       state_d;
    logic [CNT_W-1:0] cnt_d;
    logic             uev;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_HOLD;
        else        state <= state_d;
    end

    // Transitions: START (HOLD->RUN), STOP (RUN->HOLD)
    always_comb begin
        state_d = state;
        unique case (state)
            S_HOLD: if (en)  state_d = S_RUN;
            S_RUN:  if (!en) state_d = S_HOLD;
        endcase
    end

    // Counter next value; forced update beats a direct write beats a tick
    always_comb begin
        cnt_d = cnt_q;
        ovf   = 1'b0;
        if (sw_upd)
            cnt_d = '0;
        else if (cnt_wr)
            cnt_d = cnt_wdata;
        else if (tick) begin
            if (lim_act == '0)
                cnt_d = '0;
            else if (cnt_q >= lim_act) begin
                cnt_d = '0;
                ovf   = 1'b1;
            end else
                cnt_d = cnt_q + 1'b1;
        end
    end

    assign uev     = ovf | sw_upd;
    assign uif_set = ovf | (sw_upd & ~urs);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            div_act <= '0;
            lim_act <= LIM_RST;
            dma_req <= 1'b0;
        end else begin
            cnt_q   <= cnt_d;
            dma_req <= uif_set & ude;
            if (uev) begin
                div_act <= div_pre;
                lim_act <= lim_pre;
            end
        end
    end
endmodule

// File: rtl/tmr_timer.sv
module tmr_timer
    import tmr_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16,
    parameter int PSC_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq,
    output logic              dma_req
);
    localparam logic [CNT_W-1:0] LIM_RST = '1;

    logic             en, urs, uie, ude, uif;
    logic             sw_upd, cnt_wr, tick, ovf, uif_set;
    logic [CNT_W-1:0] cnt_wdata, cnt_q, lim_pre, lim_act;
    logic [PSC_W-1:0] div_pre, div_act;
    run_state_t       state;

    tmr_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W), .PSC_W(PSC_W), .LIM_RST(LIM_RST)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cnt_q(cnt_q),
        .uif_set(uif_set), .en(en), .urs(urs), .uie(uie), .ude(ude), .uif(uif),
        .div_pre(div_pre), .lim_pre(lim_pre), .sw_upd(sw_upd), .cnt_wr(cnt_wr),
        .cnt_wdata(cnt_wdata)
    );

    tmr_presc #(.PSC_W(PSC_W)) u_presc (
        .clk(clk), .rst_n(rst_n), .run(state == S_RUN), .clear(sw_upd),
        .div_act(div_act), .tick(tick)
    );

    tmr_core #(.CNT_W(CNT_W), .PSC_W(PSC_W), .LIM_RST(LIM_RST)) u_core (
        .clk(clk), .rst_n(rst_n), .en(en), .urs(urs), .ude(ude),
        .sw_upd(sw_upd), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
        .div_pre(div_pre), .lim_pre(lim_pre), .tick(tick), .state(state),
        .div_act(div_act), .lim_act(lim_act), .cnt_q(cnt_q), .ovf(ovf),
        .uif_set(uif_set), .dma_req(dma_req)
    );

    assign irq = uif & uie;
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker
    import tmr_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input run_state_t        state,
    input logic [CNT_W-1:0]  cnt_q,
    input logic [CNT_W-1:0]  lim_act,
    input logic              cnt_wr,
    input logic              sw_upd,
    input logic              urs,
    input logic              ude,
    input logic              uif,
    input logic              uif_set,
    input logic              dma_req
);
    // R2: without writes the counter only holds, steps by one, or wraps to 0
    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_wr && !sw_upd) |=> (cnt_q == $past(cnt_q) ||
                                  cnt_q == CNT_W'($past(cnt_q) + 1'b1) ||
                                  cnt_q == '0));

    // R3: in HOLD the counter does not move
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_HOLD && !cnt_wr && !sw_upd) |=> $stable(cnt_q));

    // R6: writing 0 to the flag clears it unless an update sets it
    p_uif_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == OFS_STAT && !bus_wdata[0] && !uif_set) |=> !uif);

    // R7: a silent forced update leaves the flag and DMA alone
    p_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_upd && urs) |=> (uif == $past(uif) && !dma_req));

    // R9: a DMA pulse needs the DMA enable in the previous cycle
    p_dma_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |-> $past(ude));

    // R10: a zero limit keeps a zero counter at zero
    p_lim_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (lim_act == '0 && cnt_q == '0 && !cnt_wr) |=> (cnt_q == '0));
endmodule

bind tmr_timer tmr_checker #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .state(state), .cnt_q(cnt_q), .lim_act(lim_act),
    .cnt_wr(cnt_wr), .sw_upd(sw_upd), .urs(urs), .ude(ude), .uif(uif),
    .uif_set(uif_set), .dma_req(dma_req)
);

// File: tb/tmr_timer_test.sv
module tmr_timer_test;
    import tmr_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq, dma_req;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    tmr_timer uut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .dma_req(dma_req)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        bus_addr = a; #1; d = bus_rdata;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // R2: spacing of overflow DMA pulses and the highest count reached
    task automatic period(input int p, input int lim);
        int t0, seen, maxc, cyc;
        logic [31:0] d;
        wr(OFS_CTRL, 0); wr(OFS_DIV, p); wr(OFS_LIM, lim);
        wr(OFS_IEN, 32'h100); wr(OFS_TRIG, 1); wr(OFS_CTRL, 1);
        seen = 0; maxc = 0; t0 = 0; cyc = 0;
        while (seen < 3 && cyc < 5000) begin
            @(negedge clk); cyc++;
            rd(OFS_CNT, d);
            if (int'(d[15:0]) > maxc) maxc = int'(d[15:0]);
            if (dma_req) begin
                if (seen >= 1)
                    chk(cyc - t0 == (p + 1) * (lim + 1), "R2 period", cyc - t0, (p + 1) * (lim + 1));
                t0 = cyc; seen++;
            end
        end
        chk(seen == 3, "R2 pulses", seen, 3);
        chk(maxc == lim, "R2 max count", maxc, lim);
        wr(OFS_CTRL, 0);
    endtask

    initial begin
        logic [31:0] d, c0;
        int mx;
        idle(3); rst_n = 1'b1; idle(1);

        // R1 reset values
        rd(OFS_CTRL, d); chk(d == 0, "R1 ctrl", d, 0);
        rd(OFS_IEN, d);  chk(d == 0, "R1 ien", d, 0);
        rd(OFS_STAT, d); chk(d == 0, "R1 stat", d, 0);
        rd(OFS_CNT, d);  chk(d == 0, "R1 cnt", d, 0);
        rd(OFS_DIV, d);  chk(d == 0, "R1 div", d, 0);
        rd(OFS_LIM, d);  chk(d == 32'hFFFF, "R1 lim", d, 32'hFFFF);
        chk(!irq && !dma_req, "R1 outputs", {irq, dma_req}, 0);

        // R4 preload: readback immediate, counting still on the old limit
        wr(OFS_LIM, 3); wr(OFS_DIV, 0);
        rd(OFS_LIM, d); chk(d == 3, "R4 lim readback", d, 3);
        wr(OFS_CTRL, 1); idle(12);
        rd(OFS_CNT, d); chk(d[15:0] > 3, "R4 old limit active", d, 4);

        // R5 forced update restarts and loads; trigger reads 0
        wr(OFS_TRIG, 1);
        rd(OFS_CNT, d); chk(d[15:0] == 0, "R5 restart", d[15:0], 0);
        rd(OFS_TRIG, d); chk(d == 0, "R5 trigger reads 0", d, 0);
        mx = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk); rd(OFS_CNT, d);
            if (int'(d[15:0]) > mx) mx = int'(d[15:0]);
        end
        chk(mx == 3, "R4 new limit after update", mx, 3);

        // R3 hold while disabled
        wr(OFS_CTRL, 0); idle(2);
        rd(OFS_CNT, c0); idle(20); rd(OFS_CNT, d);
        chk(d[15:0] == c0[15:0], "R3 hold", d[15:0], c0[15:0]);

        // R11 direct counter write
        wr(OFS_CNT, 2); rd(OFS_CNT, d); chk(d[15:0] == 2, "R11 cnt write", d[15:0], 2);

        // R6 flag clear, write-1 no effect, mirror in bit 31
        rd(OFS_STAT, d); chk(d[0] == 1, "R6 flag set", d[0], 1);
        rd(OFS_CNT, d); chk(d[31] == 1, "R6 mirror set", d[31], 1);
        wr(OFS_STAT, 1); rd(OFS_STAT, d); chk(d[0] == 1, "R6 write 1 keeps", d[0], 1);

        // R8 interrupt gating
        chk(irq == 0, "R8 irq masked", irq, 0);
        wr(OFS_IEN, 1); chk(irq == 1, "R8 irq on", irq, 1);
        wr(OFS_STAT, 0); rd(OFS_STAT, d); chk(d[0] == 0, "R6 write 0 clears", d[0], 0);
        chk(irq == 0, "R8 irq off after clear", irq, 0);
        rd(OFS_CNT, d); chk(d[31] == 0, "R6 mirror clear", d[31], 0);

        // R7 silent forced update, R9 pulse on a normal one
        wr(OFS_IEN, 32'h101); wr(OFS_CNT, 2); wr(OFS_CTRL, 4); wr(OFS_TRIG, 1);
        chk(dma_req == 0, "R7 no dma", dma_req, 0);
        rd(OFS_STAT, d); chk(d[0] == 0, "R7 no flag", d[0], 0);
        rd(OFS_CNT, d); chk(d[15:0] == 0, "R7 still restarts", d[15:0], 0);
        wr(OFS_CTRL, 0); wr(OFS_TRIG, 1);
        chk(dma_req == 1, "R9 dma pulse", dma_req, 1);
        idle(1); chk(dma_req == 0, "R9 pulse one cycle", dma_req, 0);
        wr(OFS_STAT, 0);

        // R10 zero limit
        wr(OFS_LIM, 0); wr(OFS_TRIG, 1); wr(OFS_STAT, 0); wr(OFS_CTRL, 1);
        mx = 0;
        for (int i = 0; i < 50; i++) begin
            @(negedge clk); rd(OFS_CNT, d);
            if (d[15:0] != 0 || dma_req) mx++;
        end
        chk(mx == 0, "R10 counter stays 0", mx, 0);
        rd(OFS_STAT, d); chk(d[0] == 0, "R10 no overflow flag", d[0], 0);
        wr(OFS_CTRL, 0);

        // R2 sweep of divide and limit, then the scaled one-second ratio
        for (int p = 0; p < 4; p++)
            for (int l = 1; l < 5; l++)
                period(p, l);
        period(19, 35);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule